// File: doc/BRIEF.md
# Sliding-Window Glitch Filter with Hysteresis

This block cleans up a slow, open-drain style serial line (a clock or data wire of a low-speed two-wire bus) whose level rings or chatters for a short time around each edge. The raw line is brought into the system clock domain through a synchronizer. A shift buffer then keeps its most recent samples, and a running total of the ones in that buffer is compared against two separate thresholds.

The filtered output goes high only when the total reaches the rise threshold. It goes low only when the total drops to the fall threshold. Between the two thresholds it keeps its level. A burst of toggles that is shorter than the window therefore delays an edge but never splits it into several edges. A short dip inside a steady level does not produce an output edge. The window length, the two thresholds and the synchronizer depth are parameters. After reset everything assumes the idle-high level of an open-drain line.

Top module: `window_hyst_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `filt_o` is 1. Reset fills the window with ones and sets the total to WIN_LEN, so an input held at 1 through and after reset gives no output edge. An input held at 0 through reset gives one falling edge, timed as in R3.
- R2: After a clean 0-to-1 step on a line that has been low for at least WIN_LEN cycles, `filt_o` rises on the (SYNC_DEPTH + RISE_AT + 1)-th rising clock edge. Edge 1 is the first edge that samples the new level. With the defaults this is edge 27.
- R3: After a clean 1-to-0 step on a line that has been high for at least WIN_LEN cycles, `filt_o` falls on the (SYNC_DEPTH + WIN_LEN − FALL_AT + 1)-th rising edge, counted the same way. With the defaults this is edge 27.
- R4: `filt_o` rises only after the ones-total has reached RISE_AT, and falls only after it has reached FALL_AT or below. While the total lies strictly between the thresholds, `filt_o` holds its level. An input alternating 1,0,1,0 on either settled level therefore leaves the output unchanged.
- R5: On a settled level, a pulse of the opposite value that lasts fewer than WIN_LEN − RISE_AT cycles produces no output edge. This holds for a single-cycle dip late in a long run of equal samples.
- R6: An edge that carries a burst of random toggles shorter than RISE_AT − FALL_AT cycles produces exactly one output transition. That transition falls no earlier than the edge's latency after the burst's first sample, and no later than the latency after the line settles.
- R7: The ones-total stays within 0..WIN_LEN. Each cycle it changes by at most one, because it adds the entering sample and subtracts the leaving one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 1 | Unsynchronized raw line |
| filt_o | output | 1 | Registered, filtered line level |

## Verification
A clean step is due exactly SYNC_DEPTH + RISE_AT + 1 edges (rise) or SYNC_DEPTH + WIN_LEN − FALL_AT + 1 edges (fall) after the edge that first samples it. The scoreboard entry for a clean step therefore carries a single expected cycle. A bursty edge can move the total by at most one per cycle, so its entry carries a cycle range. The range runs from the burst's first sample plus the latency to the settling sample plus the latency. The monitor runs half a cycle after each edge. It fails any output edge that arrives with no entry waiting, with the wrong value or outside its cycle range. Dips and alternating patterns push no entry, so any output edge they cause is reported.

// File: rtl/wgf_pkg.sv
package wgf_pkg;
  // Filtered line state held by the hysteresis stage.
  typedef enum logic [0:0] {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } line_lvl_e;

  // Width needed to hold a count from 0 up to n inclusive.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wgf_sync.sv
module wgf_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stages;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stages <= 1'b1;
        else     stages <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stages <= '1;
        else     stages <= {stages[DEPTH-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stages[DEPTH-1];
endmodule

// File: rtl/wgf_window.sv
module wgf_window #(
  parameter int WIN_LEN = 32,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  output logic [CNT_W-1:0] ones_o
);
  logic [WIN_LEN-1:0] hist;
  logic [CNT_W-1:0]   ones;
  logic               leaving;

  assign leaving = hist[WIN_LEN-1];

  // Running total: add the entering sample, drop the one leaving.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
      ones <= CNT_W'(WIN_LEN);
    end else begin
      hist <= {hist[WIN_LEN-2:0], bit_i};
      ones <= ones + CNT_W'(bit_i) - CNT_W'(leaving);
    end
  end

  assign ones_o = ones;
endmodule

// File: rtl/wgf_hyst.sv
module wgf_hyst
  import wgf_pkg::*;
#(
  parameter int RISE_AT = 24,
  parameter int FALL_AT = 8,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ones_i,
  output logic             lvl_o
);
  localparam logic [CNT_W-1:0] RISE_C = CNT_W'(RISE_AT);
  localparam logic [CNT_W-1:0] FALL_C = CNT_W'(FALL_AT);

  line_lvl_e lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (ones_i >= RISE_C)      lvl_d = LVL_HIGH;
    else if (ones_i <= FALL_C) lvl_d = LVL_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= LVL_HIGH;
    else     lvl_q <= lvl_d;
  end

  assign lvl_o = (lvl_q == LVL_HIGH);
endmodule

// File: rtl/window_hyst_filter.sv
module window_hyst_filter
  import wgf_pkg::*;
#(
  parameter int WIN_LEN    = 32,
  parameter int RISE_AT    = 24,
  parameter int FALL_AT    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = cnt_width(WIN_LEN);

  generate
    if (!(FALL_AT < RISE_AT && RISE_AT <= WIN_LEN && WIN_LEN >= 2 && SYNC_DEPTH >= 1))
    begin : g_bad_params
      $error("window_hyst_filter: need 0 <= FALL_AT < RISE_AT <= WIN_LEN, WIN_LEN >= 2");
    end
  endgenerate

  logic             line_s;
  logic [CNT_W-1:0] win_ones;

  wgf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_i),
    .q_o (line_s)
  );

  wgf_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .bit_i  (line_s),
    .ones_o (win_ones)
  );

  wgf_hyst #(.RISE_AT(RISE_AT), .FALL_AT(FALL_AT), .CNT_W(CNT_W)) u_hyst (
    .clk    (clk),
    .rst    (rst),
    .ones_i (win_ones),
    .lvl_o  (filt_o)
  );
endmodule

// File: rtl/wgf_checker.sv
module wgf_checker #(
  parameter int WIN_LEN = 32,
  parameter int RISE_AT = 24,
  parameter int FALL_AT = 8,
  parameter int CNT_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] ones,
  input logic             filt
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (filt && ones == CNT_W'(WIN_LEN)));

  p_rise_thr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(filt) |-> ($past(ones) >= CNT_W'(RISE_AT)));

  p_fall_thr_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(filt) |-> ($past(ones) <= CNT_W'(FALL_AT)));

  p_hold_band_r4: assert property (@(posedge clk) disable iff (rst)
    (ones > CNT_W'(FALL_AT) && ones < CNT_W'(RISE_AT)) |=> $stable(filt));

  p_range_r7: assert property (@(posedge clk) disable iff (rst)
    ones <= CNT_W'(WIN_LEN));

  p_unit_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ones == $past(ones)) || (ones == $past(ones) + 1'b1) || ($past(ones) == ones + 1'b1));
endmodule

bind window_hyst_filter wgf_checker #(
  .WIN_LEN (WIN_LEN),
  .RISE_AT (RISE_AT),
  .FALL_AT (FALL_AT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .ones (win_ones),
  .filt (filt_o)
);

// File: tb/window_hyst_filter_test.sv
module window_hyst_filter_test;
  localparam int WIN   = 32;
  localparam int HI    = 24;
  localparam int LO    = 8;
  localparam int SYNC  = 2;
  // Cycles from the negedge where raw changes to the negedge where filt shows it.
  localparam int D_RISE = SYNC + HI + 1;
  localparam int D_FALL = SYNC + WIN - LO + 1;
  localparam int SETTLE = WIN + D_RISE + D_FALL + 8;

  typedef struct {
    bit    val;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b1;
  logic filt;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic prev = 1'b1;
  exp_t q[$];

  window_hyst_filter #(.WIN_LEN(WIN), .RISE_AT(HI), .FALL_AT(LO), .SYNC_DEPTH(SYNC)) uut (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw),
    .filt_o (filt)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops an expectation for every output edge it sees.
  always @(negedge clk) begin
    if (!rst && filt !== prev) begin
      if (q.size() == 0) begin
        check(1'b0, "R4/R5 unexpected output edge", int'(filt), int'(prev));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(filt === e.val, {e.req, " edge value"}, int'(filt), int'(e.val));
        check(cyc >= e.lo && cyc <= e.hi, {e.req, " edge cycle"}, cyc,
              (cyc < e.lo) ? e.lo : e.hi);
      end
    end
    prev = filt;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean_step(input bit v, input string req);
    exp_t e;
    @(negedge clk);
    raw = v;
    e.val = v;
    e.lo  = cyc + (v ? D_RISE : D_FALL);
    e.hi  = e.lo;
    e.req = req;
    q.push_back(e);
    idle(SETTLE);
    check(filt === v, {req, " settled level"}, int'(filt), int'(v));
  endtask

  task automatic pulse(input bit v, input int len, input string req);
    bit base;
    base = ~v;
    @(negedge clk);
    raw = v;
    idle(len);
    raw = base;
    idle(SETTLE);
    check(filt === base, {req, " level after pulse"}, int'(filt), int'(base));
  endtask

  task automatic alternate(input int n, input string req);
    bit base;
    base = raw;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raw = ~raw;
    end
    @(negedge clk);
    raw = base;
    idle(SETTLE);
    check(filt === base, {req, " level after alternating input"}, int'(filt), int'(base));
  endtask

  task automatic burst_edge(input bit v, input int len);
    exp_t e;
    int   first;
    int   dly;
    dly = v ? D_RISE : D_FALL;
    @(negedge clk);
    raw   = v;
    first = cyc;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      raw = 1'($urandom);
    end
    @(negedge clk);
    raw   = v;
    e.val = v;
    e.lo  = first + dly;
    e.hi  = cyc + dly;
    e.req = "R6/R7";
    q.push_back(e);
    idle(SETTLE);
    check(filt === v, "R6 settled level after burst", int'(filt), int'(v));
    check(q.size() == 0, "R6 exactly one edge per burst", q.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, input idle high.
    idle(4);
    check(filt === 1'b1, "R1 output during reset", int'(filt), 1);
    rst = 1'b0;
    idle(SETTLE);
    check(filt === 1'b1, "R1 no edge with input high after reset", int'(filt), 1);

    // R1/R3: input low through reset gives exactly one timed fall.
    @(negedge clk);
    rst = 1'b1;
    raw = 1'b0;
    idle(3);
    check(filt === 1'b1, "R1 output held high in reset", int'(filt), 1);
    begin
      exp_t e;
      rst   = 1'b0;
      e.val = 1'b0;
      e.lo  = cyc + D_FALL;
      e.hi  = e.lo;
      e.req = "R1/R3";
      q.push_back(e);
    end
    @(negedge clk);
    check(filt === 1'b1, "R1 output high first cycle after reset", int'(filt), 1);
    idle(SETTLE);
    check(filt === 1'b0, "R1 fell after reset with low input", int'(filt), 0);

    // R2/R3: clean steps with exact latency.
    clean_step(1'b1, "R2");
    clean_step(1'b0, "R3");
    clean_step(1'b1, "R2");

    // R5: short dips on a high level, then short spikes on a low level.
    idle(10);
    pulse(1'b0, 1, "R5 single-cycle dip late in a run");
    pulse(1'b0, WIN - HI - 1, "R5 longest tolerated dip");
    // R4: alternating input while high.
    alternate(80, "R4 high");
    clean_step(1'b0, "R3");
    pulse(1'b1, 1, "R5 single-cycle spike");
    pulse(1'b1, WIN - HI - 1, "R5 longest tolerated spike");
    alternate(80, "R4 low");

    // R6/R7: bursty edges in both directions.
    for (int k = 0; k < 8; k++) begin
      burst_edge(k[0] ? 1'b0 : 1'b1, 3 + (k * 5) % (HI - LO - 3));
    end

    check(q.size() == 0, "R6 no missing output edge", q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule